// File: doc/BRIEF.md
# Multiplexed-Bus Burst Write Sequencer

This block produces the cycle-by-cycle waveform of a synchronous burst write to an external device whose address and data share one bus. The block works in two modes. In single-phase mode it drives the low address half and then the data. In two-phase mode it drives the upper address half, then the lower address half, and then the data. All timing is counted in functional-clock cycles, starting from a set of programmable counts. Those counts are: the cycle at which data starts, the cycle at which write enable asserts, the access time, the time per beat, and the total cycle time.

A requester starts a burst with a one-cycle request that carries the mode, the address and a beat count. It supplies data beats through a per-beat accept handshake. After the access time completes, every control signal holds still while the remaining beats go out, one beat-time each. The cycle then finishes its remaining count. When the access ends, the bus keeps the last data value. The block assumes a legal configuration. The data-start cycle is at least 1 in single-phase mode, and the write-enable cycle is at least 2 in two-phase mode. The data-start cycle and the write-enable cycle are both no later than the access time.

Top module: `mux_burst_writer`

## Requirements
- R1: After reset, csN, weN and oeN are 1; dir, busy and beatAck are 0; busOut is 0.
- R2: An accepted request makes csN low, and dir and busy high, from the cycle after acceptance, for exactly E+(N-1)*P cycles. Here E = max(cycle time, access+1), N is the effective beat count and P is the per-beat time.
- R3: In single-phase mode (reqMode=0), busOut carries reqAddr[BUS_W-1:0] for access cycles 0 to dataOn-1, and oeN stays 1 for the whole access.
- R4: In two-phase mode (reqMode=1), access cycle 0 carries reqAddr[2*BUS_W-1:BUS_W] with oeN=0. Cycles 1 to weOn-1 carry reqAddr[BUS_W-1:0] with oeN=1. The address phase ends, and data starts, at cycle weOn.
- R5: In single-phase mode, the first beat appears at cycle dataOn, whatever the write-enable cycle is, including when write enable is already low during the address phase. The first beat stays on the bus through cycle access.
- R6: weN is 0 exactly in cycles weOn to access+(N-1)*P, and 1 at all other times.
- R7: Beat k (k>=1) occupies cycles access+1+(k-1)*P to access+k*P. A per-beat time of 0 behaves as 1.
- R8: The last beat stays on busOut until the access ends. While no access is running, busOut keeps that value and dir is 0.
- R9: beatAck is high in the cycle before each beat first appears, and wrData is captured at that edge. There are exactly N such cycles per access.
- R10: A request raised while busy is ignored: the running access keeps its timing, and no new access follows it.
- R11: A beat count of 0 or 1 gives one beat with no frozen extension (N=1).
- R12: If the cycle time is at most the access time, the access lasts until the end of the last beat, that is access+1+(N-1)*P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request; accepted when busy is 0 |
| reqMode | input | 1 | 0 = single-phase address, 1 = two-phase address |
| reqAddr | input | 2*BUS_W | Start address |
| reqBeats | input | BEAT_W | Number of beats (0 treated as 1) |
| wrData | input | BUS_W | Current data beat, taken when beatAck is high |
| beatAck | output | 1 | Data beat captured at this clock edge |
| cfgDataOn | input | DON_W | First-data cycle in single-phase mode |
| cfgWeOn | input | DON_W | Write-enable assertion cycle |
| cfgAccess | input | CYC_W | Access-time cycle, the last cycle of the first beat |
| cfgBeatTime | input | BT_W | Cycles per subsequent beat |
| cfgCycle | input | CYC_W | Total write cycle time, not counting the frozen span |
| busy | output | 1 | Access in progress |
| csN | output | 1 | Chip select, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, marks the upper address half |
| dir | output | 1 | 1 = bus driven by this block |
| busOut | output | BUS_W | Shared address/data bus |

## Verification
Two events often fall in the same cycle. The access-time cycle both closes the first beat and raises the accept strobe for the second beat. With a beat time of 1, the end of one beat and the accept for the next also coincide on every cycle. The bench sweeps both address modes over several data-start, write-enable, access, beat-time, cycle-time and beat-count values, so these coincidences occur many times. In each access cycle it compares every output with values derived from the requirement formulas. A stray request raised during each access also tests rejection while busy against the end of the access.

// File: rtl/mbw_pkg.sv
`timescale 1ns/1ps
package mbw_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_BURST, PH_TAIL} phase_t;
  typedef enum logic [1:0] {SEL_ADDR_HI, SEL_ADDR_LO, SEL_DATA} busSel_t;
  typedef struct packed {
    logic    loadAddr;
    logic    capData;
    busSel_t busSel;
  } dpStrobe_t;
endpackage

// File: rtl/mbw_ctrl.sv
`timescale 1ns/1ps
module mbw_ctrl
  import mbw_pkg::*;
#(
  parameter int BEAT_W = 4,
  parameter int DON_W  = 4,
  parameter int BT_W   = 4,
  parameter int CYC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqMode,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [DON_W-1:0]  cfgDataOn,
  input  logic [DON_W-1:0]  cfgWeOn,
  input  logic [CYC_W-1:0]  cfgAccess,
  input  logic [BT_W-1:0]   cfgBeatTime,
  input  logic [CYC_W-1:0]  cfgCycle,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              csN,
  output logic              weN,
  output logic              oeN,
  output logic              dir
);
  localparam int CNT_W = ((CYC_W > DON_W) ? CYC_W : DON_W) + 1;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  accQ, cycQ, weOnQ, dataOnQ;
  logic [BT_W-1:0]   btQ, tmr;
  logic [BEAT_W-1:0] beatsLeft;
  logic              modeQ;

  logic              accept, active, atAccess, beatEnd, tailNeeded;
  logic [CNT_W-1:0]  dataStart;

  assign accept     = (phase == PH_IDLE) && reqValid;
  assign active     = (phase != PH_IDLE);
  assign dataStart  = modeQ ? weOnQ : dataOnQ;
  assign atAccess   = (phase == PH_ACC) && (cnt == accQ);
  assign beatEnd    = (phase == PH_BURST) && (tmr == '0);
  assign tailNeeded = (accQ + CNT_W'(1)) < cycQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      accQ      <= '0;
      cycQ      <= '0;
      weOnQ     <= '0;
      dataOnQ   <= '0;
      btQ       <= '0;
      tmr       <= '0;
      beatsLeft <= '0;
      modeQ     <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase     <= PH_ACC;
            cnt       <= '0;
            accQ      <= CNT_W'(cfgAccess);
            cycQ      <= CNT_W'(cfgCycle);
            weOnQ     <= CNT_W'(cfgWeOn);
            dataOnQ   <= CNT_W'(cfgDataOn);
            btQ       <= (cfgBeatTime == '0) ? BT_W'(1) : cfgBeatTime;
            beatsLeft <= (reqBeats == '0) ? '0 : reqBeats - BEAT_W'(1);
            modeQ     <= reqMode;
          end
        end
        PH_ACC: begin
          if (atAccess) begin
            if (beatsLeft != '0) begin
              phase     <= PH_BURST;
              tmr       <= btQ - BT_W'(1);
              beatsLeft <= beatsLeft - BEAT_W'(1);
            end else if (tailNeeded) begin
              phase <= PH_TAIL;
              cnt   <= cnt + CNT_W'(1);
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_BURST: begin
          if (tmr == '0) begin
            if (beatsLeft != '0) begin
              tmr       <= btQ - BT_W'(1);
              beatsLeft <= beatsLeft - BEAT_W'(1);
            end else if (tailNeeded) begin
              phase <= PH_TAIL;
              cnt   <= cnt + CNT_W'(1);
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            tmr <= tmr - BT_W'(1);
          end
        end
        PH_TAIL: begin
          if (cnt + CNT_W'(1) >= cycQ) phase <= PH_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Strobes toward the datapath
  always_comb begin
    strobe.loadAddr = accept;
    strobe.capData  = ((phase == PH_ACC) && (cnt + CNT_W'(1) == dataStart)) ||
                      (atAccess && (beatsLeft != '0)) ||
                      (beatEnd && (beatsLeft != '0));
    if ((phase == PH_ACC) && (cnt < dataStart))
      strobe.busSel = (modeQ && (cnt == '0)) ? SEL_ADDR_HI : SEL_ADDR_LO;
    else
      strobe.busSel = SEL_DATA;
  end

  // Control pins; during the burst cnt sits frozen at the access cycle
  assign busy = active;
  assign csN  = !active;
  assign dir  = active;
  assign weN  = !(active && (phase != PH_TAIL) && (cnt >= weOnQ));
  assign oeN  = !((phase == PH_ACC) && modeQ && (cnt == '0));
endmodule

// File: rtl/mbw_datapath.sv
`timescale 1ns/1ps
module mbw_datapath
  import mbw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [2*BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   busOut
);
  localparam int ADDR_W = 2 * BUS_W;

  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.loadAddr) addrQ <= reqAddr;
      if (strobe.capData)  dataQ <= wrData;
    end
  end

  // dataQ is only rewritten by a new beat, which gives bus keeping for free
  always_comb begin
    unique case (strobe.busSel)
      SEL_ADDR_HI: busOut = addrQ[ADDR_W-1:BUS_W];
      SEL_ADDR_LO: busOut = addrQ[BUS_W-1:0];
      default:     busOut = dataQ;
    endcase
  end
endmodule

// File: rtl/mux_burst_writer.sv
`timescale 1ns/1ps
module mux_burst_writer
  import mbw_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int BEAT_W = 4,
  parameter int DON_W  = 4,
  parameter int BT_W   = 4,
  parameter int CYC_W  = 5,
  localparam int ADDR_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [BUS_W-1:0]  wrData,
  output logic              beatAck,
  input  logic [DON_W-1:0]  cfgDataOn,
  input  logic [DON_W-1:0]  cfgWeOn,
  input  logic [CYC_W-1:0]  cfgAccess,
  input  logic [BT_W-1:0]   cfgBeatTime,
  input  logic [CYC_W-1:0]  cfgCycle,
  output logic              busy,
  output logic              csN,
  output logic              weN,
  output logic              oeN,
  output logic              dir,
  output logic [BUS_W-1:0]  busOut
);
  dpStrobe_t strobe;

  mbw_ctrl #(
    .BEAT_W(BEAT_W), .DON_W(DON_W), .BT_W(BT_W), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqBeats(reqBeats), .cfgDataOn(cfgDataOn), .cfgWeOn(cfgWeOn),
    .cfgAccess(cfgAccess), .cfgBeatTime(cfgBeatTime), .cfgCycle(cfgCycle),
    .strobe(strobe), .busy(busy), .csN(csN), .weN(weN), .oeN(oeN), .dir(dir)
  );

  mbw_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .wrData(wrData), .busOut(busOut)
  );

  assign beatAck = strobe.capData;
endmodule

// File: rtl/mbw_checker.sv
`timescale 1ns/1ps
module mbw_checker #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             weN,
  input logic             oeN,
  input logic             dir,
  input logic             busy,
  input logic             beatAck,
  input logic [BUS_W-1:0] busOut
);
  p_select_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (dir && busy));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (weN && oeN && !dir));

  p_keep_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> $stable(busOut));

  p_upper_half_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |=> oeN);

  p_upper_half_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> $fell(csN));

  p_ack_inside_r9: assert property (@(posedge clk) disable iff (!rstN)
    beatAck |=> !csN);
endmodule

bind mux_burst_writer mbw_checker #(.BUS_W(BUS_W)) u_mbwChk (
  .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN), .dir(dir),
  .busy(busy), .beatAck(beatAck), .busOut(busOut)
);

// File: tb/test_mux_burst_writer.sv
`timescale 1ns/1ps
module test_mux_burst_writer;
  localparam int BUS_W = 16;
  localparam int ADDR_W = 2 * BUS_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqMode = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [3:0] reqBeats = '0;
  logic [BUS_W-1:0] wrData = '0;
  logic [3:0] cfgDataOn = '0, cfgWeOn = '0, cfgBeatTime = '0;
  logic [4:0] cfgAccess = '0, cfgCycle = '0;
  logic beatAck, busy, csN, weN, oeN, dir;
  logic [BUS_W-1:0] busOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mux_burst_writer #(.BUS_W(BUS_W)) i_mux_burst_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqAddr(reqAddr), .reqBeats(reqBeats), .wrData(wrData), .beatAck(beatAck),
    .cfgDataOn(cfgDataOn), .cfgWeOn(cfgWeOn), .cfgAccess(cfgAccess),
    .cfgBeatTime(cfgBeatTime), .cfgCycle(cfgCycle), .busy(busy), .csN(csN),
    .weN(weN), .oeN(oeN), .dir(dir), .busOut(busOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  function automatic logic [BUS_W-1:0] beatVal(input int trial, input int k);
    return BUS_W'(16'hD000 + trial * 16 + k);
  endfunction

  task automatic runTrial(input int trial, input int mode, input int don, input int won,
                          input int acc, input int bt, input int cyc, input int nb);
    int nEff, pEff, eEnd, total, ds, lastEnd, idx, acks, expBeat, kk;
    logic prevAck;
    logic [ADDR_W-1:0] addr;
    string tCs, tBus;
    nEff = (nb == 0) ? 1 : nb;
    pEff = (bt == 0) ? 1 : bt;
    eEnd = (cyc > acc + 1) ? cyc : acc + 1;
    total = eEnd + (nEff - 1) * pEff;
    ds = (mode != 0) ? won : don;
    lastEnd = acc + (nEff - 1) * pEff;
    addr = 32'h1357_2468 ^ ADDR_W'(trial * 32'h0001_0103);
    tCs = (cyc <= acc) ? "R12" : ((nEff == 1) ? "R11" : "R2");

    @(negedge clk);
    reqValid = 1'b1; reqMode = mode[0]; reqAddr = addr; reqBeats = 4'(nb);
    cfgDataOn = 4'(don); cfgWeOn = 4'(won); cfgAccess = 5'(acc);
    cfgBeatTime = 4'(bt); cfgCycle = 5'(cyc);
    idx = 0; acks = 0; prevAck = 1'b0;
    wrData = beatVal(trial, 0);

    for (int t = 0; t < total + 3; t++) begin
      @(negedge clk);
      if (prevAck) idx++;
      wrData = beatVal(trial, idx);
      reqValid = (t == 1);
      if (t < total) begin
        check(tCs, csN, 0);
        check(tCs, dir, 1);
        check("R6", weN, (t >= won && t <= lastEnd) ? 0 : 1);
        check((mode != 0) ? "R4" : "R3", oeN, (mode != 0 && t == 0) ? 0 : 1);
        if (t < ds) begin
          tBus = (mode != 0) ? "R4" : "R3";
          check(tBus, busOut, (mode != 0 && t == 0) ? addr[ADDR_W-1:BUS_W] : addr[BUS_W-1:0]);
        end else begin
          if (t <= acc) begin expBeat = 0; tBus = "R5"; end
          else if (t <= lastEnd) begin expBeat = (t - acc - 1) / pEff + 1; tBus = "R7"; end
          else begin expBeat = nEff - 1; tBus = "R8"; end
          check(tBus, busOut, beatVal(trial, expBeat));
        end
        kk = ((t == ds - 1) || (nEff > 1 && t >= acc && t < lastEnd && ((t - acc) % pEff) == 0)) ? 1 : 0;
        check("R9", beatAck, kk);
      end else begin
        check("R10", csN, 1);
        check("R10", busy, 0);
        check("R8", dir, 0);
        check("R8", busOut, beatVal(trial, nEff - 1));
        check("R8", beatAck, 0);
      end
      if (beatAck) acks++;
      prevAck = beatAck;
    end
    check("R9", acks, nEff);
  endtask

  initial begin
    int trial;
    int donL[2] = '{1, 3};
    int wonL[2] = '{2, 4};
    int accL[2] = '{4, 6};
    int btL[4] = '{0, 1, 2, 3};
    int cycL[3] = '{3, 12, 20};
    int nbL[4] = '{0, 1, 2, 4};
    trial = 0;
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    check("R1", csN, 1); check("R1", weN, 1); check("R1", oeN, 1);
    check("R1", dir, 0); check("R1", busy, 0); check("R1", beatAck, 0);
    check("R1", busOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", busy, 0);
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 4; d++)
              for (int e = 0; e < 3; e++)
                for (int f = 0; f < 4; f++) begin
                  runTrial(trial, m, donL[a], wonL[b], accL[c], btL[d], cycL[e], nbL[f]);
                  trial++;
                end
    finishRun();
  end
endmodule